// File: doc/BRIEF.md
# Pre-Connection Line Wiggle Tester

This block guards the moment when a downstream channel is joined to the host-side two-wire bus. Whenever a host transaction that turns on one or more channel-select bits ends with a stop condition, each newly selected channel is tested before its switch is allowed to close. The tester pulls that channel's clock line low, then its data line. It checks that both lines really read low. It then lets go of the clock and then the data, so the release forms a stop condition on the channel. A channel whose clock or data line stays high is held off the host bus, and its bit is set in a fault register.

Channels that were already selected are left alone. Newly selected channels are queued and tested one after another, lowest index first. Every step of the sequence lasts a parameterised number of clock cycles so the lines can settle. While the test feature is off, newly selected channels are granted at once. The fault register clears when the host reads it, on reset, or when the test feature is turned off. An optional notification output reports any recorded fault.

Top module: `wiggle_check`

## Requirements
- R1: After reset, `conn_ok`, `fault_reg`, `scl_pull`, `sda_pull`, `fault_irq` and `busy` are all zero.
- R2: While `test_en` is 0, a stop strobe sets in `conn_ok` every bit that is 1 in `sel_new` and 0 in `sel_old`, at the next clock edge, and no line is pulled.
- R3: While `test_en` is 1, only channels whose bit goes from 0 (`sel_old`) to 1 (`sel_new`) at a stop strobe are tested. Channels selected in both masks keep their `conn_ok` bit and are never pulled. Changes in the select masks without a stop strobe have no effect.
- R4: A channel test pulls the clock alone for HOLD cycles, then clock and data together for 2*HOLD cycles, then data alone for HOLD cycles, and then releases both lines.
- R5: If both lines of the tested channel read low (0) at the end of the both-pulled phase, its `conn_ok` bit is set when `busy` falls. If either line reads high (1), `conn_ok` stays 0 for that channel and its bit is set in `fault_reg`.
- R6: When several channels are queued, they are tested one at a time in order of ascending index. Lines of at most one channel are pulled in any cycle.
- R7: `fault_irq` is 1 exactly when `irq_en` is 1 and `fault_reg` is nonzero.
- R8: `fault_reg` clears one cycle after a `fault_rd` strobe given while no test finishes, and one cycle after `test_en` goes to 0.
- R9: A stop strobe whose `sel_new` bit is 0 clears that channel's `conn_ok` bit. Selecting the channel again at a later stop runs the test again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| test_en | input | 1 | Pre-connection test enable |
| irq_en | input | 1 | Fault notification enable |
| stop_seen | input | 1 | One-cycle strobe: host transaction ended with stop; commit masks |
| sel_old | input | NCH | Channel-select mask before the transaction |
| sel_new | input | NCH | Channel-select mask written by the transaction |
| scl_in | input | NCH | Sampled downstream clock line levels (1 = high) |
| sda_in | input | NCH | Sampled downstream data line levels (1 = high) |
| fault_rd | input | 1 | One-cycle strobe: host read of the fault register |
| scl_pull | output | NCH | Per-channel clock pull-down enables |
| sda_pull | output | NCH | Per-channel data pull-down enables |
| conn_ok | output | NCH | Per-channel permission to close the switch |
| fault_reg | output | NCH | Per-channel stuck-high fault flags |
| fault_irq | output | 1 | Fault notification |
| busy | output | 1 | Tests queued or running |

## Verification
The bench models each channel's lines as open-drain and can stick any clock or data line high. A one-channel run measures the length of every phase and rejects any out-of-order transition. A design that released data before clock, or that sampled the lines before both were pulled, would show up as an illegal transition or a wrong phase count. A stop that adds one channel to an already connected set must pull only the new channel. A design that retested on the level of the select bit rather than on its rising edge would pull the old channel or drop its permit. Two stuck channels queued together must be tested lowest first and must both end in the fault register without being connected. Deselecting and then reselecting a channel must run the test again. Both the read strobe and turning off the test feature must empty the fault register, and the notification must follow it.

// File: rtl/wiggle_pkg.sv
package wiggle_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PCLK,
        ST_PBOTH,
        ST_CHECK,
        ST_RCLK,
        ST_RDAT
    } step_e;

    function automatic step_e next_step(step_e s);
        case (s)
            ST_PCLK:  return ST_PBOTH;
            ST_PBOTH: return ST_CHECK;
            ST_CHECK: return ST_RCLK;
            ST_RCLK:  return ST_RDAT;
            default:  return ST_IDLE;
        endcase
    endfunction

    function automatic logic clk_pulled(step_e s);
        return (s == ST_PCLK) || (s == ST_PBOTH) || (s == ST_CHECK);
    endfunction

    function automatic logic dat_pulled(step_e s);
        return (s == ST_PBOTH) || (s == ST_CHECK) || (s == ST_RCLK);
    endfunction

endpackage

// File: rtl/wiggle_sched.sv
module wiggle_sched #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           test_en,
    input  logic           stop_seen,
    input  logic [NCH-1:0] sel_old,
    input  logic [NCH-1:0] sel_new,
    input  logic           seq_busy,
    input  logic           done,
    input  logic [NCH-1:0] done_ch,
    input  logic           done_fail,
    output logic           start,
    output logic [NCH-1:0] start_ch,
    output logic [NCH-1:0] conn_ok,
    output logic           pending_any
);
    logic [NCH-1:0] pend_q, pend_d;
    logic [NCH-1:0] conn_q, conn_d;
    logic [NCH-1:0] sel_q, sel_d;
    logic [NCH-1:0] rising;

    assign rising = sel_new & ~sel_old;

    always_comb begin
        pend_d = pend_q;
        conn_d = conn_q;
        sel_d  = sel_q;
        if (done) begin
            pend_d = pend_d & ~done_ch;
            if (!done_fail)
                conn_d = conn_d | (done_ch & sel_q);
        end
        if (!test_en) begin
            conn_d = conn_d | (pend_d & sel_q);
            pend_d = '0;
        end
        if (stop_seen) begin
            sel_d  = sel_new;
            conn_d = (conn_d & sel_old & sel_new) | (test_en ? '0 : rising);
            pend_d = test_en ? ((pend_d & sel_new) | rising) : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            conn_q <= '0;
            sel_q  <= '0;
        end else begin
            pend_q <= pend_d;
            conn_q <= conn_d;
            sel_q  <= sel_d;
        end
    end

    // lowest pending channel wins
    always_comb begin
        start_ch = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend_q[i]) start_ch = NCH'(1) << i;
        end
    end

    assign start       = test_en && !seq_busy && (|pend_q);
    assign conn_ok     = conn_q;
    assign pending_any = |pend_q;

endmodule

// File: rtl/wiggle_seq.sv
module wiggle_seq
    import wiggle_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int HOLD = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           abort,
    input  logic           start,
    input  logic [NCH-1:0] start_ch,
    input  logic [NCH-1:0] scl_in,
    input  logic [NCH-1:0] sda_in,
    output logic [NCH-1:0] scl_pull,
    output logic [NCH-1:0] sda_pull,
    output logic           done,
    output logic [NCH-1:0] done_ch,
    output logic           fail,
    output logic           busy
);
    localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

    step_e          st;
    logic [CW-1:0]  cnt;
    logic [NCH-1:0] cur;
    logic           fail_q;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            cur    <= '0;
            fail_q <= 1'b0;
        end else if (st == ST_IDLE) begin
            if (start) begin
                st     <= ST_PCLK;
                cnt    <= '0;
                cur    <= start_ch;
                fail_q <= 1'b0;
            end
        end else if (cnt == LAST) begin
            cnt <= '0;
            st  <= next_step(st);
            if (st == ST_CHECK)
                fail_q <= |(cur & (scl_in | sda_in));
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign scl_pull = cur & {NCH{clk_pulled(st)}};
    assign sda_pull = cur & {NCH{dat_pulled(st)}};
    assign done     = (st == ST_RDAT) && (cnt == LAST);
    assign done_ch  = cur;
    assign fail     = fail_q;
    assign busy     = (st != ST_IDLE);

endmodule

// File: rtl/wiggle_fault.sv
module wiggle_fault #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           test_en,
    input  logic           done,
    input  logic [NCH-1:0] done_ch,
    input  logic           fail,
    input  logic           rd,
    output logic [NCH-1:0] flags
);
    logic [NCH-1:0] flags_q, flags_d;

    always_comb begin
        flags_d = rd ? '0 : flags_q;
        if (done && fail)
            flags_d = flags_d | done_ch;
        if (!test_en)
            flags_d = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_d;
    end

    assign flags = flags_q;

endmodule

// File: rtl/wiggle_check.sv
module wiggle_check #(
    parameter int NCH  = 8,
    parameter int HOLD = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           test_en,
    input  logic           irq_en,
    input  logic           stop_seen,
    input  logic [NCH-1:0] sel_old,
    input  logic [NCH-1:0] sel_new,
    input  logic [NCH-1:0] scl_in,
    input  logic [NCH-1:0] sda_in,
    input  logic           fault_rd,
    output logic [NCH-1:0] scl_pull,
    output logic [NCH-1:0] sda_pull,
    output logic [NCH-1:0] conn_ok,
    output logic [NCH-1:0] fault_reg,
    output logic           fault_irq,
    output logic           busy
);
    logic           start;
    logic [NCH-1:0] start_ch;
    logic           seq_busy;
    logic           done;
    logic [NCH-1:0] done_ch;
    logic           done_fail;
    logic           pending_any;

    wiggle_sched #(.NCH(NCH)) u_sched (
        .clk        (clk),
        .rst        (rst),
        .test_en    (test_en),
        .stop_seen  (stop_seen),
        .sel_old    (sel_old),
        .sel_new    (sel_new),
        .seq_busy   (seq_busy),
        .done       (done),
        .done_ch    (done_ch),
        .done_fail  (done_fail),
        .start      (start),
        .start_ch   (start_ch),
        .conn_ok    (conn_ok),
        .pending_any(pending_any)
    );

    wiggle_seq #(.NCH(NCH), .HOLD(HOLD)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .abort   (!test_en),
        .start   (start),
        .start_ch(start_ch),
        .scl_in  (scl_in),
        .sda_in  (sda_in),
        .scl_pull(scl_pull),
        .sda_pull(sda_pull),
        .done    (done),
        .done_ch (done_ch),
        .fail    (done_fail),
        .busy    (seq_busy)
    );

    wiggle_fault #(.NCH(NCH)) u_fault (
        .clk    (clk),
        .rst    (rst),
        .test_en(test_en),
        .done   (done),
        .done_ch(done_ch),
        .fail   (done_fail),
        .rd     (fault_rd),
        .flags  (fault_reg)
    );

    assign fault_irq = irq_en && (|fault_reg);
    assign busy      = seq_busy || pending_any;

endmodule

// File: rtl/wiggle_check_chk.sv
module wiggle_check_chk #(
    parameter int NCH = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           test_en,
    input logic           stop_seen,
    input logic           fault_rd,
    input logic [NCH-1:0] scl_pull,
    input logic [NCH-1:0] sda_pull,
    input logic [NCH-1:0] conn_ok,
    input logic [NCH-1:0] fault_reg,
    input logic           fault_irq,
    input logic           busy
);
    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (conn_ok == '0 && fault_reg == '0));

    // R6
    a_r6_single_channel: assert property (@(posedge clk) disable iff (rst)
        $onehot0(scl_pull | sda_pull));

    // R4: data is only pulled on a channel whose clock was already pulled
    a_r4_clock_first: assert property (@(posedge clk) disable iff (rst)
        (|(sda_pull & ~$past(sda_pull))) |-> (|(sda_pull & $past(scl_pull))));

    // R4: clock release leaves data still pulled
    a_r4_clock_released_first: assert property (@(posedge clk) disable iff (rst)
        ((|($past(scl_pull) & ~scl_pull)) && $past(test_en) && test_en)
            |-> (|($past(scl_pull) & sda_pull)));

    // R2
    a_r2_idle_when_off: assert property (@(posedge clk) disable iff (rst)
        (!test_en && $past(!test_en)) |-> (scl_pull == '0 && sda_pull == '0));

    // R8
    a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
        (fault_rd && !busy) |=> (fault_reg == '0));

    // R7
    a_r7_no_fault_quiet: assert property (@(posedge clk) disable iff (rst)
        (fault_reg == '0) |-> !fault_irq);

    // R5 / R9: permits only change after a stop, a finished test or a disable
    a_r5_permit_source: assert property (@(posedge clk) disable iff (rst)
        (|(conn_ok & ~$past(conn_ok)))
            |-> ($past(stop_seen) || $past(busy) || $past(!test_en)));

endmodule

bind wiggle_check wiggle_check_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .test_en  (test_en),
    .stop_seen(stop_seen),
    .fault_rd (fault_rd),
    .scl_pull (scl_pull),
    .sda_pull (sda_pull),
    .conn_ok  (conn_ok),
    .fault_reg(fault_reg),
    .fault_irq(fault_irq),
    .busy     (busy)
);

// File: tb/wiggle_check_test.sv
module wiggle_check_test;
    localparam int NCH  = 8;
    localparam int HOLD = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           test_en = 1'b0;
    logic           irq_en = 1'b0;
    logic           stop_seen = 1'b0;
    logic [NCH-1:0] sel_old = '0;
    logic [NCH-1:0] sel_new = '0;
    logic           fault_rd = 1'b0;
    logic [NCH-1:0] stuck_scl = '0;
    logic [NCH-1:0] stuck_sda = '0;
    logic [NCH-1:0] scl_in, sda_in, scl_pull, sda_pull, conn_ok, fault_reg;
    logic           fault_irq, busy;

    int n_run = 0;
    int n_fail = 0;

    // open-drain line model with optional stuck-high faults
    assign scl_in = ~scl_pull | stuck_scl;
    assign sda_in = ~sda_pull | stuck_sda;

    always #2 clk = ~clk;

    wiggle_check #(.NCH(NCH), .HOLD(HOLD)) uut (
        .clk(clk), .rst(rst), .test_en(test_en), .irq_en(irq_en),
        .stop_seen(stop_seen), .sel_old(sel_old), .sel_new(sel_new),
        .scl_in(scl_in), .sda_in(sda_in), .fault_rd(fault_rd),
        .scl_pull(scl_pull), .sda_pull(sda_pull), .conn_ok(conn_ok),
        .fault_reg(fault_reg), .fault_irq(fault_irq), .busy(busy)
    );

    // watch statistics
    int          w_clk_only, w_both, w_dat_only, w_bad, w_cycles;
    logic [NCH-1:0] w_first, w_last, w_union;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic stop_pulse(input logic [NCH-1:0] o, input logic [NCH-1:0] n);
        @(negedge clk);
        sel_old = o; sel_new = n; stop_seen = 1'b1;
        @(negedge clk);
        stop_seen = 1'b0;
    endtask

    task automatic read_fault();
        @(negedge clk);
        fault_rd = 1'b1;
        @(negedge clk);
        fault_rd = 1'b0;
    endtask

    // sample each cycle until busy drops; classify pull phases
    task automatic watch();
        logic [1:0]     prev = 2'b00;
        logic [NCH-1:0] prev_m = '0;
        w_clk_only = 0; w_both = 0; w_dat_only = 0; w_bad = 0; w_cycles = 0;
        w_first = '0; w_last = '0; w_union = '0;
        forever begin
            logic [NCH-1:0] m;
            logic [1:0]     code;
            m    = scl_pull | sda_pull;
            code = {|scl_pull, |sda_pull};
            if (m != 0) begin
                if (w_first == 0) w_first = m;
                w_last = m;
                w_union = w_union | m;
                if (prev_m != 0 && m != prev_m) w_bad++;
            end
            if ($countones(m) > 1) w_bad++;
            if (code != prev && !((prev == 2'b00 && code == 2'b10) ||
                                  (prev == 2'b10 && code == 2'b11) ||
                                  (prev == 2'b11 && code == 2'b01) ||
                                  (prev == 2'b01 && code == 2'b00))) w_bad++;
            case (code)
                2'b10: w_clk_only++;
                2'b11: w_both++;
                2'b01: w_dat_only++;
                default: ;
            endcase
            prev = code; prev_m = m;
            if (!busy || w_cycles > 2000) break;
            w_cycles++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(conn_ok == 0, "R1 conn_ok", int'(conn_ok), 0);
        chk(fault_reg == 0, "R1 fault_reg", int'(fault_reg), 0);
        chk((scl_pull | sda_pull) == 0, "R1 pulls", int'(scl_pull | sda_pull), 0);
        chk(!fault_irq && !busy, "R1 irq/busy", int'({fault_irq, busy}), 0);
    endtask

    task automatic t_disabled();
        test_en = 1'b0;
        stop_pulse(8'h00, 8'h05);
        chk(conn_ok == 8'h05, "R2 immediate grant", int'(conn_ok), 'h05);
        watch();
        chk(w_union == 0, "R2 no pulls", int'(w_union), 0);
        stop_pulse(8'h05, 8'h00);
        chk(conn_ok == 8'h00, "R9 deselect drops permit", int'(conn_ok), 0);
    endtask

    task automatic t_pass_order();
        test_en = 1'b1;
        stop_pulse(8'h00, 8'h02);
        chk(conn_ok == 8'h00 && busy, "R3 held during test", int'({busy, conn_ok}), 'h100);
        watch();
        chk(w_clk_only == HOLD, "R4 clock-only cycles", w_clk_only, HOLD);
        chk(w_both == 2 * HOLD, "R4 both-pulled cycles", w_both, 2 * HOLD);
        chk(w_dat_only == HOLD, "R4 data-only cycles", w_dat_only, HOLD);
        chk(w_bad == 0, "R4 phase order", w_bad, 0);
        chk(w_union == 8'h02, "R3 tested channel", int'(w_union), 'h02);
        chk(conn_ok == 8'h02 && fault_reg == 0, "R5 pass grants",
            int'({fault_reg, conn_ok}), 'h02);
    endtask

    task automatic t_already();
        // mask change with no stop: nothing happens
        @(negedge clk);
        sel_old = 8'h02; sel_new = 8'h0A;
        repeat (4) @(negedge clk);
        chk(!busy && conn_ok == 8'h02, "R3 no stop no action", int'({busy, conn_ok}), 'h02);
        stop_pulse(8'h02, 8'h06);
        chk(conn_ok == 8'h02, "R3 connected channel kept", int'(conn_ok), 'h02);
        watch();
        chk(w_union == 8'h04, "R3 only new channel pulled", int'(w_union), 'h04);
        chk(conn_ok == 8'h06, "R5 new channel granted", int'(conn_ok), 'h06);
    endtask

    task automatic t_fail_multi();
        stuck_scl = 8'h10; stuck_sda = 8'h20;
        irq_en = 1'b0;
        stop_pulse(8'h06, 8'h36);
        watch();
        chk(w_first == 8'h10 && w_last == 8'h20, "R6 ascending order",
            int'({w_first, w_last}), 'h1020);
        chk(w_bad == 0, "R6 one channel at a time", w_bad, 0);
        chk(fault_reg == 8'h30, "R5 stuck lines flagged", int'(fault_reg), 'h30);
        chk(conn_ok == 8'h06, "R5 stuck channels withheld", int'(conn_ok), 'h06);
        chk(!fault_irq, "R7 masked notification", int'(fault_irq), 0);
        @(negedge clk);
        irq_en = 1'b1;
        @(negedge clk);
        chk(fault_irq, "R7 notification raised", int'(fault_irq), 1);
        read_fault();
        chk(fault_reg == 0 && !fault_irq, "R8 read clears",
            int'({fault_irq, fault_reg}), 0);
        stuck_scl = '0; stuck_sda = '0;
    endtask

    task automatic t_reselect();
        stop_pulse(8'h36, 8'h06);
        chk(conn_ok == 8'h06 && !busy, "R9 deselect", int'({busy, conn_ok}), 'h06);
        stop_pulse(8'h06, 8'h16);
        watch();
        chk(w_union == 8'h10, "R9 reselect retests", int'(w_union), 'h10);
        chk(conn_ok == 8'h16 && fault_reg == 0, "R9 retest passes",
            int'({fault_reg, conn_ok}), 'h16);
        stop_pulse(8'h16, 8'h14);
        chk(conn_ok == 8'h14, "R9 drop channel 1", int'(conn_ok), 'h14);
    endtask

    task automatic t_disable_clear();
        stuck_sda = 8'h80;
        stop_pulse(8'h14, 8'h94);
        watch();
        chk(fault_reg == 8'h80, "R5 data stuck flagged", int'(fault_reg), 'h80);
        @(negedge clk);
        test_en = 1'b0;
        @(negedge clk);
        chk(fault_reg == 0 && !fault_irq, "R8 disable clears",
            int'({fault_irq, fault_reg}), 0);
        chk(conn_ok == 8'h14, "R8 permits kept", int'(conn_ok), 'h14);
        stuck_sda = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_disabled();
        t_pass_order();
        t_already();
        t_fail_multi();
        t_reselect();
        t_disable_clear();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule